// File: doc/BRIEF.md
# Staged-Access Interval Timer Channel

This block is a single 16-bit channel of an interval timer. The host never touches the down-counting element directly. A new count goes into a two-byte count register, one byte per write strobe over an 8-bit bus. Once the last byte of the programmed access pattern arrives, the full 16-bit value moves into the counting element as one word on the next counter-clock tick. Reads work the same way in the other direction: an output latch follows the counting element and hands its value out one byte at a time. A latch command freezes that value until the host has read all of it. A separate status capture exposes the programmed control bits, the output pin level and a flag that says the written count has not yet been loaded.

The channel runs a single periodic reload mode. While the gate is high, each counter-clock tick decrements the count. When the count reaches 1, the output is driven low for one tick, and the next tick reloads the count from the count register. The decrement can be plain binary or four-digit BCD.

All logic runs on one system clock. The counter clock is supplied as a one-cycle enable, `cnt_tick`.

Top module: `timer_channel`

## Requirements
- R1: After reset, `tmr_out` is 1, the access mode is low-then-high (code 2'b11), counting is binary, the counting element holds 0, and the null flag is 0.
- R2: `prog_en` with a `prog_acc` code of 2'b01, 2'b10 or 2'b11 does the following: it clears both count-register bytes, resets both byte pointers, drops any pending latches, sets the null flag, forces `tmr_out` to 1, and stops counting until a full count is written. `prog_en` with code 2'b00 has no effect.
- R3: The access code decides how bytes are written. Code 2'b01 writes bits 7:0. Code 2'b10 writes bits 15:8. Code 2'b11 writes bits 7:0 first and bits 15:8 second. The count is complete only after the last byte of the pattern.
- R4: On the first `cnt_tick` after a count is complete, the counting element takes all 16 bits of the count register at once. A half-written low-then-high count causes no transfer.
- R5: The null flag is set when a count is completed and cleared when that count is transferred.
- R6: When `cnt_tick` arrives with `gate` high, the count decrements. When `gate` is low, the count holds.
- R7: `tmr_out` goes low on the tick that brings the count to 1. On the next tick it returns high and the count reloads from the count register, so an initial count N gives a period of N ticks.
- R8: An initial count of 0 gives a period of 65536 ticks in binary and 10000 ticks in BCD.
- R9: In BCD mode (`prog_bcd`=1), each decrement borrows per 4-bit decimal digit, so 0x0100 becomes 0x0099.
- R10: An unlatched read returns the live count. With code 2'b01 a read gives the low byte. With code 2'b10 a read gives the high byte. With code 2'b11 reads alternate between the low byte and the high byte, starting with the low byte.
- R11: `latch_cmd` freezes the count value until every byte of the access pattern has been read, and tracking then resumes. A second `latch_cmd` while the value is frozen is ignored.
- R12: `stat_cmd` captures the status byte {out, null, access[1:0], 3'b000, bcd}. The next read returns this byte, ahead of any count byte. A second `stat_cmd` before that read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_en | input | 1 | Reprogram strobe |
| prog_acc | input | 2 | Access code used with prog_en |
| prog_bcd | input | 1 | BCD select used with prog_en |
| wr_en | input | 1 | Count byte write strobe |
| wr_data | input | 8 | Count byte |
| rd_en | input | 1 | Byte read strobe (consumes rd_data) |
| rd_data | output | 8 | Byte currently presented for reading |
| latch_cmd | input | 1 | Count latch command |
| stat_cmd | input | 1 | Status latch command |
| cnt_tick | input | 1 | Counter-clock edge enable |
| gate | input | 1 | Count enable |
| tmr_out | output | 1 | Timer output |

## Verification
The hardest case to reach is a latch frozen at one count while the counter keeps moving. A second latch command must have no effect in that window, and the effect is only visible once the first value has been fully read out. The stimulus latches the count, ticks twice, latches again, then reads the low byte, ticks again, and reads the high byte. The next live read must show the count after all three ticks, not the count at the second latch. The 65536-tick and 10000-tick zero-count periods are reached by holding the tick enable high for long stretches and checking the output edge on the exact tick.

// File: rtl/timer_ch_pkg.sv
package timer_ch_pkg;
  localparam int CNT_W  = 16;
  localparam int BUS_W  = 8;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  // binary decrement, wraps 0 -> all ones
  function automatic logic [CNT_W-1:0] dec_bin(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  // decimal decrement per nibble, wraps 0000 -> 9999
  function automatic logic [CNT_W-1:0] dec_bcd(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (borrow) begin
        if (v[i*4 +: 4] == 4'd0) begin
          r[i*4 +: 4] = 4'd9;
        end else begin
          r[i*4 +: 4] = v[i*4 +: 4] - 4'd1;
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] dec_count(input logic [CNT_W-1:0] v,
                                                 input logic bcd);
    return bcd ? dec_bcd(v) : dec_bin(v);
  endfunction

  function automatic logic [BUS_W-1:0] pack_status(input logic out_lvl,
                                                   input logic nul,
                                                   input acc_e acc,
                                                   input logic bcd);
    logic [BUS_W-1:0] s;
    s = '0;
    s[BUS_W-1] = out_lvl;
    s[BUS_W-2] = nul;
    s[BUS_W-3 -: 2] = acc;
    s[0] = bcd;
    return s;
  endfunction
endpackage

// File: rtl/tch_load_stage.sv
module tch_load_stage
  import timer_ch_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int BW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_ok,
  input  acc_e          acc,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_data,
  input  logic          xfer,
  output logic [CW-1:0] cr_val,
  output logic          load_pend,
  output logic          null_flag
);
  localparam int HI_W = CW - BW;

  logic [BW-1:0]   cr_lo;
  logic [HI_W-1:0] cr_hi;
  logic            wr_hi_next;

  assign cr_val = {cr_hi, cr_lo};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cr_lo      <= '0;
      cr_hi      <= '0;
      wr_hi_next <= 1'b0;
      load_pend  <= 1'b0;
      null_flag  <= 1'b0;
    end else if (prog_ok) begin
      cr_lo      <= '0;
      cr_hi      <= '0;
      wr_hi_next <= 1'b0;
      load_pend  <= 1'b0;
      null_flag  <= 1'b1;
    end else begin
      if (xfer) begin
        load_pend <= 1'b0;
        null_flag <= 1'b0;
      end
      if (wr_en) begin
        case (acc)
          ACC_HI: begin
            cr_hi     <= wr_data[HI_W-1:0];
            load_pend <= 1'b1;
            null_flag <= 1'b1;
          end
          ACC_LOHI: begin
            if (wr_hi_next) begin
              cr_hi      <= wr_data[HI_W-1:0];
              wr_hi_next <= 1'b0;
              load_pend  <= 1'b1;
              null_flag  <= 1'b1;
            end else begin
              cr_lo      <= wr_data;
              wr_hi_next <= 1'b1;
            end
          end
          default: begin
            cr_lo     <= wr_data;
            load_pend <= 1'b1;
            null_flag <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tch_count_core.sv
module tch_count_core
  import timer_ch_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_ok,
  input  logic          cnt_tick,
  input  logic          gate,
  input  logic          bcd,
  input  logic          load_pend,
  input  logic [CW-1:0] cr_val,
  output logic [CW-1:0] ce_val,
  output logic          tmr_out,
  output logic          xfer,
  output logic          reload_ev
);
  logic          armed;
  logic          dec_ev;
  logic [CW-1:0] ce_next;

  assign xfer      = cnt_tick & load_pend;
  assign dec_ev    = cnt_tick & ~load_pend & armed & gate;
  assign reload_ev = dec_ev & (ce_val == CW'(1));
  assign ce_next   = dec_count(ce_val, bcd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_val  <= '0;
      armed   <= 1'b0;
      tmr_out <= 1'b1;
    end else if (prog_ok) begin
      armed   <= 1'b0;
      tmr_out <= 1'b1;
    end else if (xfer) begin
      ce_val  <= cr_val;
      armed   <= 1'b1;
      tmr_out <= 1'b1;
    end else if (reload_ev) begin
      ce_val  <= cr_val;
      tmr_out <= 1'b1;
    end else if (dec_ev) begin
      ce_val  <= ce_next;
      tmr_out <= (ce_next != CW'(1));
    end else if (cnt_tick) begin
      tmr_out <= 1'b1;
    end
  end
endmodule

// File: rtl/tch_read_port.sv
module tch_read_port
  import timer_ch_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int BW = BUS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_ok,
  input  acc_e          acc,
  input  logic          rd_en,
  input  logic          latch_cmd,
  input  logic          stat_cmd,
  input  logic [CW-1:0] ce_val,
  input  logic [BW-1:0] status_live,
  output logic [BW-1:0] rd_data,
  output logic          frozen,
  output logic [CW-1:0] held_val
);
  localparam int HI_W = CW - BW;

  logic          rd_hi_next;
  logic          st_held;
  logic [BW-1:0] st_q;
  logic [CW-1:0] view;
  logic          pick_hi;

  assign view = frozen ? held_val : ce_val;

  always_comb begin
    case (acc)
      ACC_HI:   pick_hi = 1'b1;
      ACC_LOHI: pick_hi = rd_hi_next;
      default:  pick_hi = 1'b0;
    endcase
  end

  generate
    if (HI_W == BW) begin : g_full_hi
      assign rd_data = st_held ? st_q : (pick_hi ? view[CW-1:BW] : view[BW-1:0]);
    end else begin : g_pad_hi
      assign rd_data = st_held ? st_q
                     : (pick_hi ? {{(BW-HI_W){1'b0}}, view[CW-1:BW]} : view[BW-1:0]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_val   <= '0;
      frozen     <= 1'b0;
      rd_hi_next <= 1'b0;
      st_q       <= '0;
      st_held    <= 1'b0;
    end else if (prog_ok) begin
      frozen     <= 1'b0;
      rd_hi_next <= 1'b0;
      st_held    <= 1'b0;
    end else begin
      if (rd_en) begin
        if (st_held) begin
          st_held <= 1'b0;
        end else if (acc == ACC_LOHI) begin
          rd_hi_next <= ~rd_hi_next;
          if (rd_hi_next) frozen <= 1'b0;
        end else begin
          frozen <= 1'b0;
        end
      end
      if (latch_cmd && !frozen) begin
        held_val <= ce_val;
        frozen   <= 1'b1;
      end
      if (stat_cmd && !st_held) begin
        st_q    <= status_live;
        st_held <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/timer_channel.sv
module timer_channel
  import timer_ch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_en,
  input  logic [1:0]       prog_acc,
  input  logic             prog_bcd,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [BUS_W-1:0] rd_data,
  input  logic             latch_cmd,
  input  logic             stat_cmd,
  input  logic             cnt_tick,
  input  logic             gate,
  output logic             tmr_out
);
  acc_e             acc_q;
  logic             bcd_q;
  logic             prog_ok;
  logic             xfer;
  logic             reload_ev;
  logic             load_pend;
  logic             null_flag;
  logic [CNT_W-1:0] cr_val;
  logic [CNT_W-1:0] ce_val;
  logic             frozen;
  logic [CNT_W-1:0] held_val;
  logic [BUS_W-1:0] status_live;

  assign prog_ok     = prog_en & (prog_acc != ACC_NONE);
  assign status_live = pack_status(tmr_out, null_flag, acc_q, bcd_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= ACC_LOHI;
      bcd_q <= 1'b0;
    end else if (prog_ok) begin
      acc_q <= acc_e'(prog_acc);
      bcd_q <= prog_bcd;
    end
  end

  tch_load_stage u_load (
    .clk(clk), .rst_n(rst_n), .prog_ok(prog_ok), .acc(acc_q),
    .wr_en(wr_en), .wr_data(wr_data), .xfer(xfer),
    .cr_val(cr_val), .load_pend(load_pend), .null_flag(null_flag)
  );

  tch_count_core u_core (
    .clk(clk), .rst_n(rst_n), .prog_ok(prog_ok), .cnt_tick(cnt_tick),
    .gate(gate), .bcd(bcd_q), .load_pend(load_pend), .cr_val(cr_val),
    .ce_val(ce_val), .tmr_out(tmr_out), .xfer(xfer), .reload_ev(reload_ev)
  );

  tch_read_port u_read (
    .clk(clk), .rst_n(rst_n), .prog_ok(prog_ok), .acc(acc_q),
    .rd_en(rd_en), .latch_cmd(latch_cmd), .stat_cmd(stat_cmd),
    .ce_val(ce_val), .status_live(status_live), .rd_data(rd_data),
    .frozen(frozen), .held_val(held_val)
  );
endmodule

// File: rtl/timer_channel_chk.sv
module timer_channel_chk
  import timer_ch_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             prog_ok,
  input logic             wr_en,
  input logic             rd_en,
  input logic             cnt_tick,
  input logic             gate,
  input logic             tmr_out,
  input logic             xfer,
  input logic             reload_ev,
  input logic             load_pend,
  input logic             null_flag,
  input logic [CNT_W-1:0] cr_val,
  input logic [CNT_W-1:0] ce_val,
  input logic             frozen,
  input logic [CNT_W-1:0] held_val
);
  AST_CR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok |=> (cr_val == '0)); // R2

  AST_XFER_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !prog_ok) |=> (ce_val == $past(cr_val))); // R4

  AST_NULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_en && !prog_ok) |=> !null_flag); // R5

  AST_GATE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !gate && !load_pend) |=> $stable(ce_val)); // R6

  AST_OUT_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !tmr_out) |=> tmr_out); // R7

  AST_RELOAD_FROM_CR: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_ev && !prog_ok) |=> (ce_val == $past(cr_val))); // R7

  AST_LATCH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !rd_en && !prog_ok) |=> (frozen && $stable(held_val))); // R11
endmodule

bind timer_channel timer_channel_chk i_chk (
  .clk(clk), .rst_n(rst_n), .prog_ok(prog_ok), .wr_en(wr_en), .rd_en(rd_en),
  .cnt_tick(cnt_tick), .gate(gate), .tmr_out(tmr_out), .xfer(xfer),
  .reload_ev(reload_ev), .load_pend(load_pend), .null_flag(null_flag),
  .cr_val(cr_val), .ce_val(ce_val), .frozen(frozen), .held_val(held_val)
);

// File: tb/test_timer_channel.sv
`timescale 1ns/1ps
module test_timer_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prog_en = 1'b0;
  logic [1:0] prog_acc = 2'b00;
  logic       prog_bcd = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       latch_cmd = 1'b0;
  logic       stat_cmd = 1'b0;
  logic       cnt_tick = 1'b0;
  logic       gate = 1'b1;
  logic       tmr_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  timer_channel i_timer_channel (
    .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .prog_acc(prog_acc),
    .prog_bcd(prog_bcd), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .latch_cmd(latch_cmd), .stat_cmd(stat_cmd),
    .cnt_tick(cnt_tick), .gate(gate), .tmr_out(tmr_out)
  );

  // monitor: compares each consumed byte with the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: unexpected read, got %02h expected none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: rd_data got %02h expected %02h", t, rd_data, e);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic prog(input logic [1:0] acc, input logic bcd);
    prog_en = 1'b1; prog_acc = acc; prog_bcd = bcd;
    cyc();
    prog_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    wr_en = 1'b1; wr_data = b;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic tick(input int n);
    cnt_tick = 1'b1;
    repeat (n) cyc();
    cnt_tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1;
    cyc();
    rd_en = 1'b0;
  endtask

  task automatic stat();
    stat_cmd = 1'b1;
    cyc();
    stat_cmd = 1'b0;
  endtask

  task automatic latch();
    latch_cmd = 1'b1;
    cyc();
    latch_cmd = 1'b0;
  endtask

  task automatic chk_out(input logic e, input string t);
    checks++;
    if (tmr_out !== e) begin
      errors++;
      $display("FAIL %s: tmr_out got %0b expected %0b", t, tmr_out, e);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run incomplete, got timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    chk_out(1'b1, "R1");
    stat(); rd(8'hB0, "R1_status");
    rd(8'h00, "R1_lo"); rd(8'h00, "R1_hi");

    // R2 programming sets null flag; R4 partial write does not transfer
    prog(2'b11, 1'b0);
    stat(); rd(8'hF0, "R2_status");
    wr(8'h05);
    tick(1);
    rd(8'h00, "R4_partial_lo"); rd(8'h00, "R4_partial_hi");
    wr(8'h00);
    stat(); rd(8'hF0, "R5_null_set");
    tick(1);
    stat(); rd(8'hB0, "R5_null_clear");
    rd(8'h05, "R4_lo"); rd(8'h00, "R4_hi");

    // R7 period of 5
    tick(3); chk_out(1'b1, "R7_before");
    tick(1); chk_out(1'b0, "R7_low");
    tick(1); chk_out(1'b1, "R7_high");
    rd(8'h05, "R7_reload_lo"); rd(8'h00, "R7_reload_hi");

    // R6 gate low holds
    gate = 1'b0;
    tick(3);
    rd(8'h05, "R6_lo"); rd(8'h00, "R6_hi");
    chk_out(1'b1, "R6_out");
    gate = 1'b1;

    // R11 latch, second latch ignored
    tick(1);
    latch();
    tick(2);
    latch();
    rd(8'h04, "R11_lo");
    tick(1);
    rd(8'h00, "R11_hi");
    rd(8'h01, "R11_track_lo"); rd(8'h00, "R11_track_hi");
    tick(1);

    // R2/R3 stale high byte cleared on reprogram, low-only access
    prog(2'b11, 1'b0);
    wr(8'h00); wr(8'h12);
    tick(1);
    prog(2'b01, 1'b0);
    wr(8'h03);
    tick(1);
    rd(8'h03, "R3_lo_only"); rd(8'h03, "R10_lo_only");
    stat(); rd(8'h90, "R12_lo_mode");
    tick(1); chk_out(1'b1, "R2_cleared_a");
    tick(1); chk_out(1'b0, "R2_cleared_b");
    tick(1);

    // R3/R10 high-only access
    prog(2'b10, 1'b0);
    wr(8'h01);
    tick(1);
    rd(8'h01, "R3_hi_only");
    tick(1);
    rd(8'h00, "R10_hi_only");
    // R12 status has priority over latched count
    stat_cmd = 1'b1; latch_cmd = 1'b1;
    cyc();
    stat_cmd = 1'b0; latch_cmd = 1'b0;
    rd(8'hA0, "R12_priority");
    rd(8'h00, "R11_hi_latched");
    // R12 second status capture ignored
    stat();
    wr(8'h05);
    stat();
    rd(8'hA0, "R12_second_ignored");
    stat(); rd(8'hE0, "R12_fresh");
    // R2 code 00 ignored
    prog(2'b00, 1'b1);
    stat(); rd(8'hE0, "R2_code00_status");
    tick(1);
    rd(8'h05, "R2_code00_mode");

    // R9 BCD borrow
    prog(2'b11, 1'b1);
    wr(8'h00); wr(8'h01);
    tick(1);
    tick(1);
    rd(8'h99, "R9_lo"); rd(8'h00, "R9_hi");
    stat(); rd(8'hB1, "R12_bcd");

    // R8 zero count binary: 65536 ticks
    prog(2'b11, 1'b0);
    wr(8'h00); wr(8'h00);
    tick(1);
    tick(1);
    rd(8'hFF, "R8_bin_lo"); rd(8'hFF, "R8_bin_hi");
    tick(65533); chk_out(1'b1, "R8_bin_before");
    tick(1); chk_out(1'b0, "R8_bin_low");
    tick(1); chk_out(1'b1, "R8_bin_reload");
    rd(8'h00, "R8_bin_rl_lo"); rd(8'h00, "R8_bin_rl_hi");

    // R8 zero count BCD: 10000 ticks
    prog(2'b11, 1'b1);
    wr(8'h00); wr(8'h00);
    tick(1);
    tick(1);
    rd(8'h99, "R8_bcd_lo"); rd(8'h99, "R8_bcd_hi");
    tick(9997); chk_out(1'b1, "R8_bcd_before");
    tick(1); chk_out(1'b0, "R8_bcd_low");
    tick(1); chk_out(1'b1, "R8_bcd_reload");

    cyc();
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: pending got %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule